// File: doc/BRIEF.md
# Machine-Level Trap Controller

This block keeps the machine-level trap state of a small 32-bit core that runs in two privilege levels, machine (M) and user (U). It holds a status word (global interrupt enable, previous enable, previous privilege, modify-privilege flag), an interrupt enable word, a software-writable pending word, the trap vector, the saved exception PC and the cause word. Each cycle it looks at three interrupt lines (software, timer, external), an exception request with its cause code and faulting PC, and a return-from-trap strobe. It decides whether a trap entry or a return happens, and one cycle later it presents a redirect PC together with the new privilege level.

The pipeline around the block reads and modifies the six trap registers through a small register port. The port selects one register, gives an operation (write, set bits, clear bits) and gives the data. Reads are combinational and return the currently selected register. Every pin is a plain level or a single-cycle strobe. No interface has flow control: a strobe is acted on in the cycle it is high, and the redirect output is a one-cycle pulse that the consumer must take when it appears.

Top module: `mtrap_unit`

## Requirements
- R1: After reset the privilege is M (`2'b11`), the status, enable, pending, vector, exception-PC and cause registers read zero, and `redirect_valid_o` and `irq_taken_o` are low.
- R2: Reading the pending register (select 2) returns the stored pending word ORed with the software, timer and external lines at bit positions 3, 7 and 11.
- R3: An interrupt is taken when (visible pending AND enable) is nonzero and either the status global-enable bit (bit 3) is set or the privilege is U. In M with that bit clear, no interrupt is taken.
- R4: The cause latched on an interrupt is bit 31 set together with the index of the lowest-numbered bit that is both pending and enabled.
- R5: On any trap entry, the previous-privilege field (status bits 12:11) receives the current privilege and the privilege becomes M. The previous-enable bit (bit 7) is set if the global-enable bit was set and otherwise left unchanged. The global-enable bit is cleared. The cause is latched, and the exception PC is latched with bit 0 forced to zero. Exceptions save `exc_pc_i` and interrupts save `irq_pc_i`.
- R6: The redirect PC of a trap is the vector with bit 0 cleared, plus 4 × cause code when vector bit 0 is set and the trap is an interrupt. Exceptions always go to the base address.
- R7: On a return, the privilege is loaded from the previous-privilege field and that field is set to U. The modify-privilege bit (17) is cleared when the new privilege is U. The global-enable bit takes the previous-enable value, the previous-enable bit is cleared, and the redirect PC is the saved exception PC.
- R8: Register writes are masked. The exception PC (select 4) forces bit 0 to zero, the vector (select 3) forces bit 1 to zero, and the cause (select 5) keeps only bits 31 and 3:0. A previous-privilege value of 00 stores U and any other value stores M.
- R9: Operation codes are 1 for write, 2 for set and 3 for clear. Set and clear combine the data with the stored register value; for the pending register this is the stored word without the interrupt lines. Code 0 does nothing.
- R10: An exception takes priority over a return, and a return takes priority over an interrupt. A register operation in a cycle with a trap entry or a return is dropped. The redirect and `irq_taken_o` pulses appear in the cycle after the event.
- R11: Only status bits 3, 7, 12:11 and 17 are stored, and the other status bits read zero. Selects 6 and 7 read zero and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_sw_i | input | 1 | Software interrupt line |
| irq_tmr_i | input | 1 | Timer interrupt line |
| irq_ext_i | input | 1 | External interrupt line |
| exc_valid_i | input | 1 | Exception request strobe |
| exc_cause_i | input | 5 | Exception cause code |
| exc_pc_i | input | 32 | PC of the faulting instruction |
| ret_i | input | 1 | Return-from-trap strobe |
| irq_pc_i | input | 32 | PC to save if an interrupt is taken |
| csr_sel_i | input | 3 | Register select (0 status, 1 enable, 2 pending, 3 vector, 4 exception PC, 5 cause) |
| csr_op_i | input | 2 | Register operation (0 none, 1 write, 2 set, 3 clear) |
| csr_wdata_i | input | 32 | Register operation data |
| csr_rdata_o | output | 32 | Value of the selected register |
| redirect_valid_o | output | 1 | One-cycle pulse: fetch from `redirect_pc_o` |
| redirect_pc_o | output | 32 | Trap target or return address |
| priv_o | output | 2 | Current privilege (11 M, 00 U) |
| irq_taken_o | output | 1 | One-cycle pulse: the last redirect was an interrupt |

## Verification
The hardest case to reach is an interrupt taken in U mode while the global-enable bit is clear. The only way into U is a return with the previous-privilege field at 00. A directed sequence arms the enable word while in M, checks that a pending line is then ignored, and issues a return from the reset state to drop into U, where the same line must trap. The random phase mixes returns, exceptions, masked status writes and interrupt lines, so the privilege moves between U and M many times. The bench model tracks every transition cycle by cycle.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;

  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_M = 2'b11;

  // status word bit positions
  localparam int ST_GIE_BIT   = 3;
  localparam int ST_PGIE_BIT  = 7;
  localparam int ST_PPRIV_LO  = 11;
  localparam int ST_PPRIV_HI  = 12;
  localparam int ST_MPRV_BIT  = 17;

  // interrupt line positions in the pending word
  localparam int LINE_SW_BIT  = 3;
  localparam int LINE_TMR_BIT = 7;
  localparam int LINE_EXT_BIT = 11;

  typedef enum logic [2:0] {
    SEL_STATUS  = 3'd0,
    SEL_ENABLE  = 3'd1,
    SEL_PENDING = 3'd2,
    SEL_VECTOR  = 3'd3,
    SEL_EPC     = 3'd4,
    SEL_CAUSE   = 3'd5
  } csr_sel_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csr_op_e;

  typedef struct packed {
    logic       mprv;
    logic [1:0] ppriv;
    logic       pgie;
    logic       gie;
  } status_t;

endpackage

// File: rtl/mtrap_lowest.sv
module mtrap_lowest #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  logic [W-1:0] onehot;

  // isolate the lowest set bit, then encode its position
  assign onehot = vec & (~vec + W'(1));
  assign any    = |vec;

  for (genvar b = 0; b < IW; b++) begin : g_bit
    logic [W-1:0] hit;
    for (genvar i = 0; i < W; i++) begin : g_in
      if (((i >> b) & 1) != 0) begin : g_on
        assign hit[i] = onehot[i];
      end else begin : g_off
        assign hit[i] = 1'b0;
      end
    end
    assign idx[b] = |hit;
  end
endmodule

// File: rtl/mtrap_merge.sv
module mtrap_merge
  import mtrap_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [1:0]   op,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] data,
  output logic [W-1:0] nxt
);
  always_comb begin
    unique case (csr_op_e'(op))
      OP_WRITE: nxt = data;
      OP_SET:   nxt = cur | data;
      OP_CLEAR: nxt = cur & ~data;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/mtrap_target.sv
module mtrap_target #(
  parameter int W  = 32,
  parameter int CW = 5
) (
  input  logic [W-1:0]  vec,
  input  logic          is_irq,
  input  logic [CW-1:0] code,
  output logic [W-1:0]  pc
);
  logic [W-1:0] base;
  logic [W-1:0] offset;

  assign base   = {vec[W-1:1], 1'b0};
  assign offset = {{(W-CW-2){1'b0}}, code, 2'b00};
  assign pc     = (vec[0] && is_irq) ? base + offset : base;
endmodule

// File: rtl/mtrap_unit.sv
module mtrap_unit
  import mtrap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      irq_sw_i,
  input  logic                      irq_tmr_i,
  input  logic                      irq_ext_i,
  input  logic                      exc_valid_i,
  input  logic [$clog2(XLEN)-1:0]   exc_cause_i,
  input  logic [XLEN-1:0]           exc_pc_i,
  input  logic                      ret_i,
  input  logic [XLEN-1:0]           irq_pc_i,
  input  logic [2:0]                csr_sel_i,
  input  logic [1:0]                csr_op_i,
  input  logic [XLEN-1:0]           csr_wdata_i,
  output logic [XLEN-1:0]           csr_rdata_o,
  output logic                      redirect_valid_o,
  output logic [XLEN-1:0]           redirect_pc_o,
  output logic [1:0]                priv_o,
  output logic                      irq_taken_o
);
  localparam int CW = $clog2(XLEN);
  localparam logic [XLEN-1:0] CAUSE_KEEP = {1'b1, {(XLEN-5){1'b0}}, 4'hF};
  localparam logic [XLEN-1:0] VEC_KEEP   = ~(XLEN'(2));
  localparam logic [XLEN-1:0] EPC_KEEP   = ~(XLEN'(1));

  status_t         st_q;
  logic [1:0]      priv_q;
  logic [XLEN-1:0] en_q, pend_q, vec_q, epc_q, cause_q;
  logic            rv_q, it_q;
  logic [XLEN-1:0] rpc_q;

  // interrupt lines placed at their pending positions
  logic [XLEN-1:0] lines, vis_pend, armed;
  always_comb begin
    lines = '0;
    lines[LINE_SW_BIT]  = irq_sw_i;
    lines[LINE_TMR_BIT] = irq_tmr_i;
    lines[LINE_EXT_BIT] = irq_ext_i;
  end
  assign vis_pend = pend_q | lines;
  assign armed    = vis_pend & en_q;

  logic          armed_any;
  logic [CW-1:0] armed_idx;
  mtrap_lowest #(.W(XLEN), .IW(CW)) u_lowest (
    .vec (armed),
    .any (armed_any),
    .idx (armed_idx)
  );

  // event arbitration: exception > return > interrupt
  logic irq_ok, take_exc, take_ret, take_irq, enter;
  assign irq_ok   = armed_any && (st_q.gie || priv_q == PRIV_U);
  assign take_exc = exc_valid_i;
  assign take_ret = ret_i && !exc_valid_i;
  assign take_irq = irq_ok && !exc_valid_i && !ret_i;
  assign enter    = take_exc || take_irq;

  logic [CW-1:0]   trap_code;
  logic [XLEN-1:0] trap_cause, trap_epc, trap_pc, next_pc;
  assign trap_code  = take_exc ? exc_cause_i : armed_idx;
  assign trap_cause = {take_irq, {(XLEN-CW-1){1'b0}}, trap_code};
  assign trap_epc   = (take_exc ? exc_pc_i : irq_pc_i) & EPC_KEEP;

  mtrap_target #(.W(XLEN), .CW(CW)) u_target (
    .vec    (vec_q),
    .is_irq (take_irq),
    .code   (trap_code),
    .pc     (trap_pc)
  );
  assign next_pc = take_ret ? epc_q : trap_pc;

  // register view
  logic [XLEN-1:0] st_view;
  always_comb begin
    st_view = '0;
    st_view[ST_GIE_BIT]               = st_q.gie;
    st_view[ST_PGIE_BIT]              = st_q.pgie;
    st_view[ST_PPRIV_HI:ST_PPRIV_LO]  = st_q.ppriv;
    st_view[ST_MPRV_BIT]              = st_q.mprv;
  end

  logic [XLEN-1:0] stored_val;
  always_comb begin
    csr_rdata_o = '0;
    stored_val  = '0;
    case (csr_sel_e'(csr_sel_i))
      SEL_STATUS:  begin csr_rdata_o = st_view;  stored_val = st_view;  end
      SEL_ENABLE:  begin csr_rdata_o = en_q;     stored_val = en_q;     end
      SEL_PENDING: begin csr_rdata_o = vis_pend; stored_val = pend_q;   end
      SEL_VECTOR:  begin csr_rdata_o = vec_q;    stored_val = vec_q;    end
      SEL_EPC:     begin csr_rdata_o = epc_q;    stored_val = epc_q;    end
      SEL_CAUSE:   begin csr_rdata_o = cause_q;  stored_val = cause_q;  end
      default:     begin csr_rdata_o = '0;       stored_val = '0;       end
    endcase
  end

  logic [XLEN-1:0] wval;
  mtrap_merge #(.W(XLEN)) u_merge (
    .op   (csr_op_i),
    .cur  (stored_val),
    .data (csr_wdata_i),
    .nxt  (wval)
  );

  logic wr_en;
  assign wr_en = (csr_op_e'(csr_op_i) != OP_NONE) && !enter && !take_ret;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= '0;
      priv_q  <= PRIV_M;
      en_q    <= '0;
      pend_q  <= '0;
      vec_q   <= '0;
      epc_q   <= '0;
      cause_q <= '0;
      rv_q    <= 1'b0;
      it_q    <= 1'b0;
      rpc_q   <= '0;
    end else begin
      rv_q <= enter || take_ret;
      it_q <= take_irq;
      if (enter || take_ret) rpc_q <= next_pc;

      if (enter) begin
        st_q.ppriv <= priv_q;
        priv_q     <= PRIV_M;
        if (st_q.gie) st_q.pgie <= 1'b1;
        st_q.gie   <= 1'b0;
        cause_q    <= trap_cause;
        epc_q      <= trap_epc;
      end else if (take_ret) begin
        priv_q     <= st_q.ppriv;
        st_q.ppriv <= PRIV_U;
        if (st_q.ppriv != PRIV_M) st_q.mprv <= 1'b0;
        st_q.gie   <= st_q.pgie;
        st_q.pgie  <= 1'b0;
      end else if (wr_en) begin
        case (csr_sel_e'(csr_sel_i))
          SEL_STATUS: begin
            st_q.gie   <= wval[ST_GIE_BIT];
            st_q.pgie  <= wval[ST_PGIE_BIT];
            st_q.ppriv <= (|wval[ST_PPRIV_HI:ST_PPRIV_LO]) ? PRIV_M : PRIV_U;
            st_q.mprv  <= wval[ST_MPRV_BIT];
          end
          SEL_ENABLE:  en_q    <= wval;
          SEL_PENDING: pend_q  <= wval;
          SEL_VECTOR:  vec_q   <= wval & VEC_KEEP;
          SEL_EPC:     epc_q   <= wval & EPC_KEEP;
          SEL_CAUSE:   cause_q <= wval & CAUSE_KEEP;
          default: ;
        endcase
      end
    end
  end

  assign redirect_valid_o = rv_q;
  assign redirect_pc_o    = rpc_q;
  assign priv_o           = priv_q;
  assign irq_taken_o      = it_q;
endmodule

// File: rtl/mtrap_unit_chk.sv
module mtrap_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       exc_valid_i,
  input logic       ret_i,
  input logic [1:0] csr_op_i,
  input logic [1:0] priv_o,
  input logic       redirect_valid_o,
  input logic       redirect_pc_bit0,
  input logic       irq_taken_o,
  input logic       gie_q,
  input logic [1:0] ppriv_q,
  input logic       cause_msb
);
  AST_EXC_ENTERS_M: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid_i |=> (priv_o == 2'b11 && redirect_valid_o && !irq_taken_o)); // R5
  AST_ENTRY_CLEARS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_taken_o |-> !gie_q); // R5
  AST_IRQ_CAUSE_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    irq_taken_o |-> (cause_msb && priv_o == 2'b11 && redirect_valid_o)); // R4
  AST_IRQ_MASKED_IN_M: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_o == 2'b11 && !gie_q) |=> !irq_taken_o); // R3
  AST_RET_LOADS_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !exc_valid_i) |=> (priv_o == $past(ppriv_q) && redirect_valid_o)); // R7
  AST_PRIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_o == 2'b11 || priv_o == 2'b00)); // R8
  AST_REDIRECT_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid_o |-> !redirect_pc_bit0); // R6
  AST_EXC_NO_CSR_OP: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid_i |-> csr_op_i == 2'b00); // R10
endmodule

bind mtrap_unit mtrap_unit_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .exc_valid_i      (exc_valid_i),
  .ret_i            (ret_i),
  .csr_op_i         (csr_op_i),
  .priv_o           (priv_o),
  .redirect_valid_o (redirect_valid_o),
  .redirect_pc_bit0 (redirect_pc_o[0]),
  .irq_taken_o      (irq_taken_o),
  .gie_q            (st_q.gie),
  .ppriv_q          (st_q.ppriv),
  .cause_msb        (cause_q[XLEN-1])
);

// File: tb/mtrap_unit_tb.sv
`timescale 1ns/1ps
module mtrap_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_sw_i = 0, irq_tmr_i = 0, irq_ext_i = 0;
  logic        exc_valid_i = 0;
  logic [4:0]  exc_cause_i = '0;
  logic [31:0] exc_pc_i = '0;
  logic        ret_i = 0;
  logic [31:0] irq_pc_i = '0;
  logic [2:0]  csr_sel_i = '0;
  logic [1:0]  csr_op_i = '0;
  logic [31:0] csr_wdata_i = '0;
  logic [31:0] csr_rdata_o;
  logic        redirect_valid_o;
  logic [31:0] redirect_pc_o;
  logic [1:0]  priv_o;
  logic        irq_taken_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mtrap_unit u_dut (.*);

  // reference model state
  logic [1:0]  m_priv = 2'b11, m_ppriv = 2'b00;
  logic        m_gie = 0, m_pgie = 0, m_mprv = 0;
  logic [31:0] m_en = '0, m_pend = '0, m_vec = '0, m_epc = '0, m_cause = '0;

  function automatic logic [31:0] st_view();
    logic [31:0] r = '0;
    r[3] = m_gie; r[7] = m_pgie; r[12:11] = m_ppriv; r[17] = m_mprv;
    return r;
  endfunction

  function automatic logic [31:0] model_read(input logic [2:0] sel, input logic [31:0] lines);
    case (sel)
      3'd0: return st_view();
      3'd1: return m_en;
      3'd2: return m_pend | lines;
      3'd3: return m_vec;
      3'd4: return m_epc;
      3'd5: return m_cause;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic sw, input logic tm, input logic ex,
                     input logic exc, input logic [4:0] ecode, input logic [31:0] epc,
                     input logic ret, input logic [31:0] ipc,
                     input logic [2:0] sel, input logic [1:0] op, input logic [31:0] wd,
                     input string tag);
    logic [31:0] lines, armed, exp_pc, cur, v;
    logic        ok, t_exc, t_ret, t_irq;
    int          idx;
    @(negedge clk);
    irq_sw_i = sw; irq_tmr_i = tm; irq_ext_i = ex;
    exc_valid_i = exc; exc_cause_i = ecode; exc_pc_i = epc;
    ret_i = ret; irq_pc_i = ipc;
    csr_sel_i = sel; csr_op_i = exc ? 2'b00 : op; csr_wdata_i = wd;
    #1;
    lines = '0; lines[3] = sw; lines[7] = tm; lines[11] = ex;
    chk({tag, " read"}, csr_rdata_o, model_read(sel, lines));
    chk({tag, " priv"}, {30'b0, priv_o}, {30'b0, m_priv});
    armed = (m_pend | lines) & m_en;
    idx = 0;
    for (int i = 31; i >= 0; i--) if (armed[i]) idx = i;
    ok    = (armed != 0) && (m_gie || m_priv == 2'b00);
    t_exc = exc;
    t_ret = ret && !exc;
    t_irq = ok && !exc && !ret;
    if (t_ret) exp_pc = m_epc;
    else if (t_irq && m_vec[0]) exp_pc = (m_vec & ~32'h1) + 32'(4 * idx);
    else exp_pc = m_vec & ~32'h1;
    @(posedge clk);
    #1;
    chk({tag, " redirect valid"}, {31'b0, redirect_valid_o}, {31'b0, (t_exc | t_ret | t_irq)});
    chk({tag, " irq taken"}, {31'b0, irq_taken_o}, {31'b0, t_irq});
    if (t_exc | t_ret | t_irq) chk({tag, " redirect pc"}, redirect_pc_o, exp_pc);
    // advance model
    if (t_exc || t_irq) begin
      m_ppriv = m_priv; m_priv = 2'b11;
      if (m_gie) m_pgie = 1'b1;
      m_gie = 1'b0;
      m_cause = t_exc ? {27'b0, ecode} : (32'h8000_0000 | 32'(idx));
      m_epc = (t_exc ? epc : ipc) & ~32'h1;
    end else if (t_ret) begin
      m_priv = m_ppriv;
      if (m_ppriv != 2'b11) m_mprv = 1'b0;
      m_ppriv = 2'b00;
      m_gie = m_pgie; m_pgie = 1'b0;
    end else if (op != 2'b00) begin
      cur = (sel == 3'd2) ? m_pend : model_read(sel, '0);
      case (op)
        2'd1: v = wd;
        2'd2: v = cur | wd;
        default: v = cur & ~wd;
      endcase
      case (sel)
        3'd0: begin
          m_gie = v[3]; m_pgie = v[7]; m_mprv = v[17];
          m_ppriv = (|v[12:11]) ? 2'b11 : 2'b00;
        end
        3'd1: m_en = v;
        3'd2: m_pend = v;
        3'd3: m_vec = v & ~32'h2;
        3'd4: m_epc = v & ~32'h1;
        3'd5: m_cause = v & 32'h8000_000F;
        default: ;
      endcase
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [1:0] op, input logic [31:0] wd, input string tag);
    cyc(0, 0, 0, 0, 5'd0, 32'h0, 0, 32'h0, sel, op, wd, tag);
  endtask

  task automatic rd(input logic [2:0] sel, input string tag);
    cyc(0, 0, 0, 0, 5'd0, 32'h0, 0, 32'h0, sel, 2'b00, 32'h0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset priv", {30'b0, priv_o}, 32'h3);
    chk("R1 reset redirect", {31'b0, redirect_valid_o}, 32'h0);
    chk("R1 reset irq flag", {31'b0, irq_taken_o}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < 6; s++) rd(3'(s), "R1 reset value");

    // R8 masks
    wr(3'd4, 2'd1, 32'hFFFF_FFFF, "R8 epc mask");
    rd(3'd4, "R8 epc read");
    wr(3'd3, 2'd1, 32'hFFFF_FFFF, "R8 vector mask");
    rd(3'd3, "R8 vector read");
    wr(3'd5, 2'd1, 32'hFFFF_FFFF, "R8 cause mask");
    rd(3'd5, "R8 cause read");
    wr(3'd0, 2'd1, 32'h0000_0800, "R8 ppriv warl");
    rd(3'd0, "R8 ppriv read");
    // R11 status bits and unused selects
    wr(3'd0, 2'd1, 32'hFFFF_FFFF, "R11 status write");
    rd(3'd0, "R11 status read");
    wr(3'd6, 2'd1, 32'hFFFF_FFFF, "R11 unused write");
    rd(3'd6, "R11 unused read");
    wr(3'd0, 2'd1, 32'h0, "R11 status clear");
    // R9 set and clear
    wr(3'd1, 2'd1, 32'h0000_00F0, "R9 write");
    wr(3'd1, 2'd2, 32'h0000_0F00, "R9 set");
    wr(3'd1, 2'd3, 32'h0000_0030, "R9 clear");
    rd(3'd1, "R9 read");
    wr(3'd1, 2'd0, 32'hFFFF_FFFF, "R9 no-op");
    rd(3'd1, "R9 no-op read");
    // R2 pending view with lines, enable off
    wr(3'd1, 2'd1, 32'h0, "R2 disarm");
    wr(3'd2, 2'd1, 32'h0000_0100, "R2 stored");
    cyc(1, 1, 1, 0, 0, 0, 0, 0, 3'd2, 2'd0, 0, "R2 lines");
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 3'd2, 2'd2, 32'h1, "R2 R9 set uses stored");
    rd(3'd2, "R2 after set");
    wr(3'd2, 2'd1, 32'h0, "R2 clear stored");
    // R3 masked in M, then taken in U with gie clear
    wr(3'd1, 2'd1, 32'hFFFF_FFFF, "R3 arm");
    cyc(1, 0, 0, 0, 0, 0, 0, 32'h444, 3'd0, 2'd0, 0, "R3 masked in M");
    wr(3'd4, 2'd1, 32'h0000_2000, "R7 set epc");
    wr(3'd0, 2'd1, 32'h0002_0000, "R7 set mprv");
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 3'd0, 2'd0, 0, "R7 return to U");
    rd(3'd0, "R7 status after return");
    cyc(1, 0, 0, 0, 0, 0, 0, 32'h0000_3001, 3'd0, 2'd0, 0, "R3 taken in U");
    rd(3'd5, "R4 cause sw");
    rd(3'd4, "R5 epc saved");
    rd(3'd0, "R5 status after entry");
    // R4 lowest index among several
    wr(3'd2, 2'd1, 32'h0001_0000, "R4 stored pending");
    cyc(0, 1, 1, 0, 0, 0, 0, 32'h50, 3'd0, 2'd1, 32'h8, "R4 enable gie");
    cyc(0, 1, 1, 0, 0, 0, 0, 32'h54, 3'd5, 2'd0, 0, "R4 lowest taken");
    rd(3'd5, "R4 cause read");
    rd(3'd0, "R5 pgie set");
    // R6 vectored interrupt vs exception
    wr(3'd3, 2'd1, 32'h0000_0101, "R6 vector mode");
    wr(3'd0, 2'd2, 32'h8, "R6 gie");
    rd(3'd0, "R6 vectored irq");
    cyc(0, 0, 0, 1, 5'd2, 32'h777, 0, 0, 3'd0, 2'd0, 0, "R6 exception base");
    rd(3'd5, "R6 cause");
    // R10 priority
    wr(3'd0, 2'd2, 32'h8, "R10 gie");
    cyc(1, 1, 1, 1, 5'd13, 32'h900, 1, 32'h880, 3'd5, 2'd0, 0, "R10 exc wins");
    wr(3'd0, 2'd2, 32'h8, "R10 gie again");
    cyc(1, 0, 0, 0, 0, 0, 1, 32'h880, 3'd1, 2'd1, 32'h0, "R10 return wins op dropped");
    rd(3'd1, "R10 enable kept");
    wr(3'd2, 2'd1, 32'h0, "R10 clear pending");
    wr(3'd3, 2'd1, 32'h0, "R10 clear vector");

    for (int n = 0; n < 4000; n++) begin
      logic       e, r;
      logic [1:0] op;
      logic [31:0] wd;
      e  = ($urandom % 16) == 0;
      r  = ($urandom % 8) == 0;
      op = (($urandom % 2) == 0) ? 2'(($urandom % 3) + 1) : 2'd0;
      wd = (($urandom % 2) == 0) ? $urandom : ($urandom & 32'h0002_1888);
      cyc(($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0,
          e, 5'($urandom), $urandom, r, $urandom,
          3'($urandom), op, wd, "R3/R4/R5/R6/R7/R9 random");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule